// File: doc/BRIEF.md
# Coherent-Averaging Lock-In Detector

This block recovers the in-phase and quadrature content of a periodic signal whose period is an exact number of samples. Accepted samples are folded into a buffer that holds one period, one entry per phase position. Each entry collects the sum of the samples at that phase over a window of several consecutive periods. When a window closes, a single multiply-accumulate engine walks the folded period once. It weights each entry by a cosine and a sine reference value, so a result costs one pass of multiply-accumulates no matter how many periods were folded.

The buffer is doubled. While one half is being demodulated, the next window already fills the other half, so a continuous sample stream loses nothing. Each window yields one I/Q pair. The pair is the raw, unscaled sums, marked by a single-cycle strobe.

Top module: `lia_coh_lockin`

## Requirements
- R1: A sample is taken only in a cycle with `in_valid` high. Each taken sample advances a phase index that runs 0..PERIOD-1 and then wraps to 0. Cycles with `in_valid` low change nothing, whatever `in_sample` carries.
- R2: A window spans AVG_CNT consecutive periods of taken samples. Buffer entry k ends the window holding the signed sum of the AVG_CNT samples taken at phase k. The first period of a window overwrites the entry, so nothing carries over from an earlier window.
- R3: `out_i` equals the sum over k of entry[k]·COS_TAB[k], and `out_q` equals the sum over k of entry[k]·SIN_TAB[k]. Both are signed and unscaled. Reference entry k sits at bits [k·REF_W +: REF_W] of its packed table.
- R4: The buffer is SAMPLE_W+clog2(AVG_CNT) bits wide and the outputs are that width plus REF_W+clog2(PERIOD) bits. With full-scale inputs, both sums come out exact.
- R5: `out_valid` is high for exactly one cycle. It rises PERIOD clock edges after the edge that takes the last sample of the window.
- R6: `out_i` and `out_q` change only together with an `out_valid` pulse and hold their value in between.
- R7: Windows fed back to back with `in_valid` held high each give a correct result. Samples that arrive during a demodulation pass are kept.
- R8: A synchronous reset (`rst` high at a clock edge) clears `out_valid`, `out_i` and `out_q` to 0 and discards any partial window. The next window starts at phase 0 of its first period.
- R9: Each completed window gives exactly one result, and no `out_valid` pulse appears before the first window completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | SAMPLE_W | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_i | output | ACC_W | Signed in-phase sum |
| out_q | output | ACC_W | Signed quadrature sum |

## Verification
The bench builds the block with its defaults: 12-bit samples, 8-bit references, an 8-sample period and 4-period windows, which gives 14-bit buffer entries and 25-bit results. At these sizes a window is only 32 samples, so six windows can run back to back with no gaps. That exercises the bank swap at the moment a result leaves while the next window is already filling. The small period also puts the fixed latency, the overwrite on a window's first period and a mid-window reset within a few hundred cycles. A full-scale pattern with sign-matched references drives the sums close to the largest value the chosen widths must hold.

// File: rtl/lia_pkg.sv
package lia_pkg;

    // Bits needed to index or count 'n' items (at least one).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a signed sum of 'count' terms of 'base' bits.
    function automatic int sum_width(input int base, input int count);
        return base + ((count > 1) ? $clog2(count) : 0);
    endfunction

endpackage

// File: rtl/lia_phase_seq.sv
module lia_phase_seq #(
    parameter int PERIOD  = 8,
    parameter int AVG_CNT = 4,
    localparam int PH_W   = lia_pkg::idx_width(PERIOD),
    localparam int PR_W   = lia_pkg::idx_width(AVG_CNT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic [PH_W-1:0] phase,
    output logic            first_pass,
    output logic            wr_bank,
    output logic            window_done
);
    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic [PR_W-1:0] period;
        logic            bank;
    } seq_t;

    seq_t st_d, st_q;
    logic last_phase, last_period;

    always_comb begin
        st_d        = st_q;
        last_phase  = (st_q.phase == PH_W'(PERIOD - 1));
        last_period = (st_q.period == PR_W'(AVG_CNT - 1));
        window_done = in_valid && last_phase && last_period;
        if (in_valid) begin
            if (last_phase) begin
                st_d.phase = '0;
                if (last_period) begin
                    st_d.period = '0;
                    st_d.bank   = ~st_q.bank;
                end else begin
                    st_d.period = st_q.period + 1'b1;
                end
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign phase      = st_q.phase;
    assign first_pass = (st_q.period == '0);
    assign wr_bank    = st_q.bank;

    // R1: the phase index never leaves 0..PERIOD-1
    a_r1_phase_bound: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.phase) < PERIOD);
    // R2: the period count never leaves 0..AVG_CNT-1
    a_r2_period_bound: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.period) < AVG_CNT);
    // R7: a completed window hands its bank over to the demodulator
    a_r7_bank_swap: assert property (@(posedge clk) disable iff (rst)
        window_done |=> (st_q.bank != $past(st_q.bank)));
endmodule

// File: rtl/lia_avg_bank.sv
module lia_avg_bank #(
    parameter int SAMPLE_W = 12,
    parameter int AVG_W    = 14,
    parameter int PERIOD   = 8,
    localparam int PH_W    = lia_pkg::idx_width(PERIOD)
) (
    input  logic                       clk,
    input  logic                       wr_en,
    input  logic                       wr_bank,
    input  logic [PH_W-1:0]            wr_idx,
    input  logic                       first_pass,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic [PH_W-1:0]            rd_idx,
    output logic signed [AVG_W-1:0]    rd_data
);
    logic signed [AVG_W-1:0] mem_d [2][PERIOD];
    logic signed [AVG_W-1:0] mem_q [2][PERIOD];
    logic signed [AVG_W-1:0] ext;

    always_comb begin
        mem_d = mem_q;
        ext   = AVG_W'(sample);
        if (wr_en) begin
            if (first_pass) mem_d[wr_bank][wr_idx] = ext;
            else            mem_d[wr_bank][wr_idx] = mem_q[wr_bank][wr_idx] + ext;
        end
    end

    // Every entry is rewritten on a window's first period, so no reset is needed.
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_data = mem_q[~wr_bank][rd_idx];
endmodule

// File: rtl/lia_ref_rom.sv
module lia_ref_rom #(
    parameter int REF_W  = 8,
    parameter int PERIOD = 8,
    parameter logic [PERIOD*REF_W-1:0] COS_TAB = '0,
    parameter logic [PERIOD*REF_W-1:0] SIN_TAB = '0,
    localparam int PH_W  = lia_pkg::idx_width(PERIOD)
) (
    input  logic [PH_W-1:0]         idx,
    output logic signed [REF_W-1:0] cos_o,
    output logic signed [REF_W-1:0] sin_o
);
    logic signed [REF_W-1:0] cos_arr [PERIOD];
    logic signed [REF_W-1:0] sin_arr [PERIOD];

    for (genvar k = 0; k < PERIOD; k++) begin : g_tab
        assign cos_arr[k] = COS_TAB[k*REF_W +: REF_W];
        assign sin_arr[k] = SIN_TAB[k*REF_W +: REF_W];
    end

    assign cos_o = cos_arr[idx];
    assign sin_o = sin_arr[idx];
endmodule

// File: rtl/lia_demod.sv
module lia_demod #(
    parameter int AVG_W  = 14,
    parameter int REF_W  = 8,
    parameter int ACC_W  = 25,
    parameter int PERIOD = 8,
    localparam int PH_W  = lia_pkg::idx_width(PERIOD),
    localparam int PROD_W = AVG_W + REF_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [AVG_W-1:0] avg_in,
    input  logic signed [REF_W-1:0] cos_in,
    input  logic signed [REF_W-1:0] sin_in,
    output logic [PH_W-1:0]         rd_idx,
    output logic                    out_valid,
    output logic signed [ACC_W-1:0] out_i,
    output logic signed [ACC_W-1:0] out_q
);
    typedef struct packed {
        logic                    busy;
        logic [PH_W-1:0]         idx;
        logic signed [ACC_W-1:0] acc_i;
        logic signed [ACC_W-1:0] acc_q;
        logic signed [ACC_W-1:0] res_i;
        logic signed [ACC_W-1:0] res_q;
        logic                    vld;
    } dm_t;

    dm_t dm_d, dm_q;
    logic signed [PROD_W-1:0] prod_i, prod_q;
    logic signed [ACC_W-1:0]  sum_i, sum_q;
    logic                     last_idx;

    always_comb begin
        dm_d     = dm_q;
        dm_d.vld = 1'b0;
        prod_i   = PROD_W'(avg_in) * PROD_W'(cos_in);
        prod_q   = PROD_W'(avg_in) * PROD_W'(sin_in);
        sum_i    = dm_q.acc_i + ACC_W'(prod_i);
        sum_q    = dm_q.acc_q + ACC_W'(prod_q);
        last_idx = (dm_q.idx == PH_W'(PERIOD - 1));
        if (dm_q.busy) begin
            if (last_idx) begin
                dm_d.res_i = sum_i;
                dm_d.res_q = sum_q;
                dm_d.vld   = 1'b1;
                dm_d.busy  = 1'b0;
            end else begin
                dm_d.acc_i = sum_i;
                dm_d.acc_q = sum_q;
                dm_d.idx   = dm_q.idx + 1'b1;
            end
        end
        if (start) begin
            dm_d.busy  = 1'b1;
            dm_d.idx   = '0;
            dm_d.acc_i = '0;
            dm_d.acc_q = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dm_q <= '0;
        else     dm_q <= dm_d;
    end

    assign rd_idx    = dm_q.idx;
    assign out_valid = dm_q.vld;
    assign out_i     = dm_q.res_i;
    assign out_q     = dm_q.res_q;

    // R5: the strobe never lasts two cycles
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R6: results hold between strobes
    a_r6_hold_i: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_i));
    a_r6_hold_q: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_q));
    // R7: a new window only starts once the previous pass is on its last entry
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        start |-> (!dm_q.busy || last_idx));
    // R9: a strobe always follows a pass
    a_r9_after_pass: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(dm_q.busy));
endmodule

// File: rtl/lia_coh_lockin.sv
module lia_coh_lockin #(
    parameter int SAMPLE_W = 12,
    parameter int REF_W    = 8,
    parameter int PERIOD   = 8,
    parameter int AVG_CNT  = 4,
    parameter logic [PERIOD*REF_W-1:0] COS_TAB = 64'h5A00A681A6005A7F,
    parameter logic [PERIOD*REF_W-1:0] SIN_TAB = 64'hA681A6005A7F5A00,
    localparam int AVG_W   = lia_pkg::sum_width(SAMPLE_W, AVG_CNT),
    localparam int ACC_W   = lia_pkg::sum_width(AVG_W + REF_W, PERIOD),
    localparam int PH_W    = lia_pkg::idx_width(PERIOD)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_sample,
    output logic                       out_valid,
    output logic signed [ACC_W-1:0]    out_i,
    output logic signed [ACC_W-1:0]    out_q
);
    logic [PH_W-1:0]         phase, rd_idx;
    logic                    first_pass, wr_bank, window_done;
    logic signed [AVG_W-1:0] avg_rd;
    logic signed [REF_W-1:0] cos_v, sin_v;

    lia_phase_seq #(.PERIOD(PERIOD), .AVG_CNT(AVG_CNT)) u_seq (
        .clk(clk), .rst(rst), .in_valid(in_valid), .phase(phase),
        .first_pass(first_pass), .wr_bank(wr_bank), .window_done(window_done)
    );

    lia_avg_bank #(.SAMPLE_W(SAMPLE_W), .AVG_W(AVG_W), .PERIOD(PERIOD)) u_bank (
        .clk(clk), .wr_en(in_valid), .wr_bank(wr_bank), .wr_idx(phase),
        .first_pass(first_pass), .sample(in_sample), .rd_idx(rd_idx), .rd_data(avg_rd)
    );

    lia_ref_rom #(.REF_W(REF_W), .PERIOD(PERIOD), .COS_TAB(COS_TAB), .SIN_TAB(SIN_TAB)) u_rom (
        .idx(rd_idx), .cos_o(cos_v), .sin_o(sin_v)
    );

    lia_demod #(.AVG_W(AVG_W), .REF_W(REF_W), .ACC_W(ACC_W), .PERIOD(PERIOD)) u_dm (
        .clk(clk), .rst(rst), .start(window_done), .avg_in(avg_rd),
        .cos_in(cos_v), .sin_in(sin_v), .rd_idx(rd_idx),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // R8: reset leaves the strobe low on the following cycle
    a_r8_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/lia_coh_lockin_test.sv
module lia_coh_lockin_test;
    localparam int SW = 12;
    localparam int M = 8;
    localparam int NCA = 4;
    localparam int ACCW = 25;
    localparam int NV = 5;

    localparam int COS_T [M] = '{127, 90, 0, -90, -127, -90, 0, 90};
    localparam int SIN_T [M] = '{0, 90, 127, 90, 0, -90, -127, -90};

    // Stimulus vectors: cosine amplitude, sine amplitude, offset, alternating jitter, idle gaps
    localparam int V_AC  [NV] = '{1500, 0, -900, 400, 0};
    localparam int V_AS  [NV] = '{0, 1200, 700, -1600, 0};
    localparam int V_OF  [NV] = '{0, 100, -50, 300, -700};
    localparam int V_JT  [NV] = '{0, 200, 37, 5, 400};
    localparam int V_GAP [NV] = '{0, 0, 1, 0, 0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [SW-1:0] in_sample = '0;
    logic out_valid;
    logic signed [ACCW-1:0] out_i, out_q;

    always #2 clk = ~clk;

    lia_coh_lockin uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_push = 0;
    int n_seen = 0;
    longint exp_i [16];
    longint exp_q [16];
    int exp_cyc [16];
    string exp_tag [16];
    bit prev_vld = 1'b0;
    logic signed [ACCW-1:0] held_i = '0, held_q = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic int smp(input int v, input int p, input int k);
        return V_OF[v] + (V_AC[v] * COS_T[k] + V_AS[v] * SIN_T[k]) / 128
               + (((p % 2) == 1) ? V_JT[v] : -V_JT[v]);
    endfunction

    // Drives one full window; fs selects the full-scale pattern. Leaves in_valid high.
    task automatic run_window(input int v, input bit fs, input string tag);
        int acc [M];
        longint ei, eq;
        for (int k = 0; k < M; k++) acc[k] = 0;
        for (int p = 0; p < NCA; p++) begin
            for (int k = 0; k < M; k++) begin
                int s;
                s = fs ? ((COS_T[k] < 0) ? -2048 : 2047) : smp(v, p, k);
                if (!fs && V_GAP[v] != 0) begin
                    @(negedge clk);
                    in_valid  = 1'b0;     // R1: garbage on an idle cycle
                    in_sample = 12'sh7FF;
                end
                @(negedge clk);
                in_valid  = 1'b1;
                in_sample = SW'(s);
                acc[k] += s;
            end
        end
        ei = 0;
        eq = 0;
        for (int k = 0; k < M; k++) begin
            ei += longint'(acc[k]) * COS_T[k];
            eq += longint'(acc[k]) * SIN_T[k];
        end
        exp_i[n_push]   = ei;
        exp_q[n_push]   = eq;
        exp_cyc[n_push] = cyc + 1 + M;   // R5: last sample taken at edge cyc+1
        exp_tag[n_push] = tag;
        n_push++;
    endtask

    // Monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            prev_vld = 1'b0;
            held_i = '0;
            held_q = '0;
        end else begin
            if (out_valid) begin
                if (n_seen >= n_push) begin
                    check(1'b0, "R9 unexpected strobe", 1, 0);
                end else begin
                    check(longint'(out_i) == exp_i[n_seen], {exp_tag[n_seen], " out_i"}, out_i, exp_i[n_seen]);
                    check(longint'(out_q) == exp_q[n_seen], {exp_tag[n_seen], " out_q"}, out_q, exp_q[n_seen]);
                    check(cyc == exp_cyc[n_seen], "R5 strobe cycle", cyc, exp_cyc[n_seen]);
                    n_seen++;
                end
                check(!prev_vld, "R5 strobe width", 1, 0);
                held_i = out_i;
                held_q = out_q;
            end else if (prev_vld) begin
                check(out_i == held_i && out_q == held_q, "R6 hold", out_i, held_i);
            end
            prev_vld = out_valid;
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            check(1'b0, "R9 watchdog expired", cyc, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
        check(out_i == '0, "R8 reset out_i", out_i, 0);
        check(out_q == '0, "R8 reset out_q", out_q, 0);
        rst = 1'b0;

        // Vector table walked back to back (R2, R3, R7; vector 2 carries idle gaps for R1)
        for (int v = 0; v < NV; v++) begin
            run_window(v, 1'b0, (V_GAP[v] != 0) ? "R1" : "R3");
        end
        run_window(0, 1'b1, "R4");        // full-scale, R4
        @(negedge clk);
        in_valid = 1'b0;
        repeat (M + 4) @(negedge clk);
        check(n_seen == n_push, "R9 result count", n_seen, n_push);

        // R8: reset in the middle of a window discards it
        for (int k = 0; k < 13; k++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = 12'sd2000;
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0 && out_i == '0, "R8 mid reset", out_i, 0);
        rst = 1'b0;
        run_window(1, 1'b0, "R8");        // R2: first period overwrites stale entries
        @(negedge clk);
        in_valid = 1'b0;
        repeat (M + 4) @(negedge clk);
        check(n_seen == n_push, "R9 result count after reset", n_seen, n_push);
        finish_run();
    end
endmodule